// File: doc/BRIEF.md
# Ethernet receive frame classifier

This block sits beside a receive byte stream and classifies each Ethernet frame as it passes. Bytes arrive one per clock with a valid qualifier and start/end markers; the first byte is the first destination-address byte, the last one is the final FCS byte. The block reads the length/type word, steps over at most two VLAN tags, and recognises MAC control frames together with their opcode. It also counts the frame length and checks it against a declared payload length when the frame carries one.

One cycle after the end-of-frame byte the block produces a single-cycle result. The result holds a forward/drop decision, a flag asking the flow-control logic to process the frame, and a five-bit error vector. Downstream logic uses the decision to gate the frame toward the client. It uses the flag to start pause handling, and it merges the error bits into the per-frame status. CRC checking, the data path and pause timing belong to other blocks.

Top module: `eth_rx_classifier`

## Requirements
- R1: After reset all outputs are 0. `res_valid` is high for exactly one cycle: the cycle after a byte is accepted with `in_valid` and `in_eop` both high. It is low in every other cycle.
- R2: A length/type word below 0x0600 is a declared payload length L. Error bit 4 (`res_err[4]`) is set when L exceeds the real payload, which is frame bytes minus 18 minus 4 per VLAN tag. When L is equal to or smaller than the real payload (padding), bit 4 stays 0.
- R3: A length/type word of 0x0600 or above, other than a tag or control value, makes the frame forwarded with no length comparison.
- R4: A word of 0x8100 is a VLAN tag, and the word four bytes later is decoded in its place. At most two tags are skipped. A third 0x8100 is treated as an ordinary EtherType.
- R5: A word of 0x8808 marks a control frame whose next two bytes form the opcode. Control frames are dropped when `cfg_fwd_ctrl` is 0 and forwarded when it is 1. In a result, `res_forward` and `res_drop` are always opposite.
- R6: `res_pause` is 1 only for a control frame with opcode 0x0001 or 0x0101. It does not depend on `cfg_fwd_ctrl`.
- R7: Frames of fewer than 64 bytes set `res_err[2]`. Frames of more than 1518 bytes set `res_err[3]`. Frames of 64 to 1518 bytes set neither. Bits 1:0 are always 0.
- R8: The size bits and the length bit combine freely (2 with 4, 3 with 4), and no error bit causes a drop by itself.
- R9: A frame that ends before its length/type word is complete, or a control frame that ends before its opcode is complete, is forwarded. It gets no pause flag and no length error, only the size bits.
- R10: Cycles with `in_valid` low do not advance the frame. A byte with `in_sop` high restarts classification, even if the previous frame never ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte qualifier |
| in_sop | input | 1 | First byte of frame |
| in_eop | input | 1 | Last byte of frame |
| in_data | input | 8 | Frame byte |
| cfg_fwd_ctrl | input | 1 | 1: pass control frames to the client |
| res_valid | output | 1 | Result strobe |
| res_forward | output | 1 | Frame goes to the client |
| res_drop | output | 1 | Frame is discarded |
| res_pause | output | 1 | Pause or priority flow control frame seen |
| res_err | output | 5 | Bit 2 undersize, bit 3 oversize, bit 4 length mismatch |

## Verification
The assertions assume that `in_sop` and `in_eop` are only meaningful together with `in_valid`. They also assume that `cfg_fwd_ctrl` is stable from the end-of-frame byte to the result cycle. The bench drives the markers only with valid bytes and changes the configuration only between frames. Frames are sent back to back, with idle gaps and as aborted fragments, and every frame length stays below the counter's saturation limit.

// File: rtl/erc_pkg.sv
package erc_pkg;
  typedef enum logic [2:0] {
    KIND_NONE,
    KIND_LEN,
    KIND_TYPE,
    KIND_CTRL_PEND,
    KIND_CTRL
  } kind_e;

  localparam logic [15:0] LT_VLAN     = 16'h8100;
  localparam logic [15:0] LT_CTRL     = 16'h8808;
  localparam logic [15:0] LT_TYPE_MIN = 16'h0600;
  localparam logic [15:0] OP_PAUSE    = 16'h0001;
  localparam logic [15:0] OP_PFC      = 16'h0101;

  localparam int ADDR_BYTES = 12;
  localparam int TAG_BYTES  = 4;
  localparam int OVERHEAD   = 18;

  localparam int ERR_W     = 5;
  localparam int ERR_UNDER = 2;
  localparam int ERR_OVER  = 3;
  localparam int ERR_LEN   = 4;
endpackage

// File: rtl/erc_frame_counter.sv
module erc_frame_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_sop,
  output logic [CNT_W-1:0] idx,
  output logic [CNT_W-1:0] size_now
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    idx      = (in_valid && in_sop) ? '0 : cnt_q;
    size_now = (idx == CNT_MAX) ? CNT_MAX : idx + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)           cnt_q <= '0;
    else if (in_valid) cnt_q <= size_now;
  end

  p_count_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(cnt_q));
  p_sop_restart_r10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_sop) |=> (cnt_q == CNT_W'(1)));
endmodule

// File: rtl/erc_field_decoder.sv
module erc_field_decoder
  import erc_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int MAX_TAGS = 2,
  localparam int TAG_W   = $clog2(MAX_TAGS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_sop,
  input  logic [7:0]       in_data,
  input  logic [CNT_W-1:0] idx,
  output kind_e            nxt_kind,
  output logic [TAG_W-1:0] nxt_tags,
  output logic [15:0]      nxt_decl,
  output logic [15:0]      nxt_opcode
);
  kind_e            kind_q, b_kind;
  logic [TAG_W-1:0] tags_q, b_tags;
  logic [15:0]      decl_q, b_decl, op_q, b_op;
  logic [7:0]       hi_q;
  logic [CNT_W-1:0] field_pos;
  logic [15:0]      word;
  logic             restart;

  always_comb begin
    restart   = in_valid && in_sop;
    b_kind    = restart ? KIND_NONE : kind_q;
    b_tags    = restart ? '0 : tags_q;
    b_decl    = restart ? '0 : decl_q;
    b_op      = restart ? '0 : op_q;
    field_pos = CNT_W'(ADDR_BYTES + TAG_BYTES * int'(b_tags));
    word      = {hi_q, in_data};

    nxt_kind   = b_kind;
    nxt_tags   = b_tags;
    nxt_decl   = b_decl;
    nxt_opcode = b_op;

    if (in_valid) begin
      if (b_kind == KIND_NONE && idx == field_pos + CNT_W'(1)) begin
        if (word == LT_VLAN && int'(b_tags) < MAX_TAGS) begin
          nxt_tags = b_tags + TAG_W'(1);
        end else if (word < LT_TYPE_MIN) begin
          nxt_kind = KIND_LEN;
          nxt_decl = word;
        end else if (word == LT_CTRL) begin
          nxt_kind = KIND_CTRL_PEND;
        end else begin
          nxt_kind = KIND_TYPE;
        end
      end else if (b_kind == KIND_CTRL_PEND && idx == field_pos + CNT_W'(3)) begin
        nxt_kind   = KIND_CTRL;
        nxt_opcode = word;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q <= KIND_NONE;
      tags_q <= '0;
      decl_q <= '0;
      op_q   <= '0;
      hi_q   <= '0;
    end else if (in_valid) begin
      kind_q <= nxt_kind;
      tags_q <= nxt_tags;
      decl_q <= nxt_decl;
      op_q   <= nxt_opcode;
      hi_q   <= in_data;
    end
  end

  p_tag_limit_r4: assert property (@(posedge clk) disable iff (rst)
    int'(tags_q) <= MAX_TAGS);
  p_len_range_r2: assert property (@(posedge clk) disable iff (rst)
    (kind_q == KIND_LEN) |-> (decl_q < LT_TYPE_MIN));
  p_kind_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(kind_q));
endmodule

// File: rtl/erc_error_check.sv
module erc_error_check
  import erc_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int TAG_W     = 2,
  parameter int MIN_FRAME = 64,
  parameter int MAX_FRAME = 1518,
  localparam int SUM_W    = ((CNT_W > 16) ? CNT_W : 16) + 3
) (
  input  logic [CNT_W-1:0] size,
  input  kind_e            kind,
  input  logic [TAG_W-1:0] tags,
  input  logic [15:0]      decl,
  output logic [ERR_W-1:0] err
);
  logic [SUM_W-1:0] needed;

  always_comb begin
    needed = SUM_W'(decl) + SUM_W'(OVERHEAD) + SUM_W'(TAG_BYTES * int'(tags));
    err = '0;
    err[ERR_UNDER] = SUM_W'(size) < SUM_W'(MIN_FRAME);
    err[ERR_OVER]  = SUM_W'(size) > SUM_W'(MAX_FRAME);
    err[ERR_LEN]   = (kind == KIND_LEN) && (needed > SUM_W'(size));
  end
endmodule

// File: rtl/eth_rx_classifier.sv
module eth_rx_classifier
  import erc_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int MAX_TAGS  = 2,
  parameter int MIN_FRAME = 64,
  parameter int MAX_FRAME = 1518
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_sop,
  input  logic             in_eop,
  input  logic [7:0]       in_data,
  input  logic             cfg_fwd_ctrl,
  output logic             res_valid,
  output logic             res_forward,
  output logic             res_drop,
  output logic             res_pause,
  output logic [ERR_W-1:0] res_err
);
  localparam int TAG_W = $clog2(MAX_TAGS + 1);

  logic [CNT_W-1:0] idx, size_now;
  kind_e            kind;
  logic [TAG_W-1:0] tags;
  logic [15:0]      decl, opcode;
  logic [ERR_W-1:0] err;
  logic             fire, is_ctrl, is_pause;

  erc_frame_counter #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop),
    .idx(idx), .size_now(size_now)
  );

  erc_field_decoder #(.CNT_W(CNT_W), .MAX_TAGS(MAX_TAGS)) u_decode (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop),
    .in_data(in_data), .idx(idx), .nxt_kind(kind), .nxt_tags(tags),
    .nxt_decl(decl), .nxt_opcode(opcode)
  );

  erc_error_check #(.CNT_W(CNT_W), .TAG_W(TAG_W), .MIN_FRAME(MIN_FRAME),
                    .MAX_FRAME(MAX_FRAME)) u_err (
    .size(size_now), .kind(kind), .tags(tags), .decl(decl), .err(err)
  );

  always_comb begin
    fire     = in_valid && in_eop;
    is_ctrl  = (kind == KIND_CTRL);
    is_pause = is_ctrl && (opcode == OP_PAUSE || opcode == OP_PFC);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid   <= 1'b0;
      res_forward <= 1'b0;
      res_drop    <= 1'b0;
      res_pause   <= 1'b0;
      res_err     <= '0;
    end else begin
      res_valid   <= fire;
      res_forward <= fire && !(is_ctrl && !cfg_fwd_ctrl);
      res_drop    <= fire && is_ctrl && !cfg_fwd_ctrl;
      res_pause   <= fire && is_pause;
      res_err     <= fire ? err : '0;
    end
  end

  p_result_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_eop) |=> res_valid);
  p_result_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_eop) |=> !res_valid);
  p_fwd_xor_drop_r5: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_forward != res_drop));
  p_drop_cfg_r5: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_drop) |-> $past(!cfg_fwd_ctrl));
  p_pause_strobe_r6: assert property (@(posedge clk) disable iff (rst)
    res_pause |-> res_valid);
  p_err_low_bits_r7: assert property (@(posedge clk) disable iff (rst)
    res_err[1:0] == 2'b00);
  p_size_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(res_err[ERR_UNDER] && res_err[ERR_OVER]));
endmodule

// File: tb/eth_rx_classifier_tb_top.sv
`timescale 1ns/1ps
module eth_rx_classifier_tb_top;
  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 0, in_sop = 0, in_eop = 0, cfg_fwd_ctrl = 0;
  logic [7:0] in_data = '0;
  logic res_valid, res_forward, res_drop, res_pause;
  logic [4:0] res_err;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  typedef struct packed {
    logic fwd; logic drop; logic pause; logic [4:0] err;
  } exp_t;
  exp_t  exp_q[$];
  string tag_q[$];
  logic [7:0] fb [0:1599];

  always #2.5 clk = ~clk;

  eth_rx_classifier dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop),
    .in_eop(in_eop), .in_data(in_data), .cfg_fwd_ctrl(cfg_fwd_ctrl),
    .res_valid(res_valid), .res_forward(res_forward), .res_drop(res_drop),
    .res_pause(res_pause), .res_err(res_err)
  );

  function automatic exp_t model(int size, int tags, int lt, int op, bit fwd);
    exp_t e;
    int hdr;
    e = '0;
    hdr = 12 + 4 * tags;
    e.err[2] = size < 64;
    e.err[3] = size > 1518;
    e.fwd = 1'b1;
    if (size >= hdr + 2) begin
      if (lt < 'h600) begin
        e.err[4] = (lt + 18 + 4 * tags) > size;
      end else if (lt == 'h8808 && size >= hdr + 4) begin
        e.pause = (op == 'h0001) || (op == 'h0101);
        e.drop  = !fwd;
        e.fwd   = fwd;
      end
    end
    return e;
  endfunction

  task automatic idle(int n);
    repeat (n) begin
      @(posedge clk); #1;
      in_valid = 0; in_sop = 0; in_eop = 0;
    end
  endtask

  task automatic send_frame(string tag, int size, int tags, int lt, int op,
                            bit fwd, bit gaps);
    int pos;
    for (int i = 0; i < 1600; i++) fb[i] = 8'h5A;
    for (int i = 0; i < 12; i++) fb[i] = 8'(8'hA0 + i);
    pos = 12;
    for (int t = 0; t < tags; t++) begin
      fb[pos] = 8'h81; fb[pos+1] = 8'h00; fb[pos+2] = 8'h20; fb[pos+3] = 8'h05;
      pos += 4;
    end
    fb[pos] = 8'(lt >> 8); fb[pos+1] = 8'(lt);
    fb[pos+2] = 8'(op >> 8); fb[pos+3] = 8'(op);
    exp_q.push_back(model(size, tags, lt, op, fwd));
    tag_q.push_back(tag);
    for (int i = 0; i < size; i++) begin
      @(posedge clk); #1;
      cfg_fwd_ctrl = fwd;
      in_valid = 1; in_sop = (i == 0); in_eop = (i == size - 1);
      in_data = fb[i];
      if (gaps && (i % 5 == 2) && i != size - 1) idle(2);
    end
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && res_valid) begin
        if (exp_q.size() == 0) begin
          n_checks++; n_fail++;
          $display("FAIL R1 unexpected result actual=1 expected=0");
        end else begin
          exp_t e; string t;
          e = exp_q.pop_front(); t = tag_q.pop_front();
          check(t, {24'd0, res_forward, res_drop, res_pause, res_err}, {24'd0, e});
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    check("R1 reset", {27'd0, res_valid, res_forward, res_drop, res_pause, |res_err}, 32'd0);

    send_frame("R2 exact length", 64, 0, 46, 0, 0, 0);
    send_frame("R2 declared too long", 64, 0, 50, 0, 0, 0);
    send_frame("R2 padded", 64, 0, 10, 0, 0, 0);
    send_frame("R3 ethertype", 100, 0, 'h0800, 0, 0, 0);
    send_frame("R7 short type", 60, 0, 'h0800, 0, 0, 0);
    send_frame("R7 63 bytes", 63, 0, 'h0800, 0, 0, 0);
    send_frame("R7 1518 bytes", 1518, 0, 'h0800, 0, 0, 0);
    send_frame("R7 1519 bytes", 1519, 0, 'h0800, 0, 0, 0);
    send_frame("R4 one tag ok", 64, 1, 42, 0, 0, 0);
    send_frame("R4 one tag long", 64, 1, 43, 0, 0, 0);
    send_frame("R4 two tags ok", 64, 2, 38, 0, 0, 0);
    send_frame("R4 two tags long", 64, 2, 100, 0, 0, 0);
    send_frame("R4 third tag", 80, 2, 'h8100, 0, 0, 0);
    send_frame("R5 R6 pause dropped", 64, 0, 'h8808, 'h0001, 0, 0);
    send_frame("R5 R6 pause forwarded", 64, 0, 'h8808, 'h0001, 1, 0);
    send_frame("R6 pfc", 64, 0, 'h8808, 'h0101, 0, 0);
    send_frame("R6 other opcode", 64, 0, 'h8808, 'h0002, 0, 0);
    send_frame("R5 tagged ctrl", 70, 1, 'h8808, 'h0101, 1, 0);
    send_frame("R8 under and length", 40, 0, 100, 0, 0, 0);
    send_frame("R8 over and length", 1520, 0, 1535, 0, 0, 0);
    send_frame("R8 short ctrl", 60, 0, 'h8808, 'h0001, 0, 0);
    send_frame("R9 no length field", 13, 0, 'h8808, 'h0001, 0, 0);
    send_frame("R9 no opcode", 15, 0, 'h8808, 'h0001, 0, 0);
    send_frame("R9 single byte", 1, 0, 0, 0, 0, 0);
    send_frame("R10 gaps", 64, 1, 43, 0, 0, 1);
    send_frame("R10 gaps ctrl", 64, 0, 'h8808, 'h0001, 0, 1);
    idle(3);
    // R10: aborted fragment without end marker, then a full frame
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); #1;
      in_valid = 1; in_sop = (i == 0); in_eop = 0;
      in_data = (i == 12) ? 8'h88 : ((i == 13) ? 8'h08 : 8'h00);
    end
    send_frame("R10 restart", 64, 0, 46, 0, 0, 0);
    idle(5);
    check("R1 all results seen", exp_q.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule